// File: doc/BRIEF.md
# Receive Buffer Readiness Indicator

This block decides what a receiver's single interrupt pin shows while a host talks to it over SPI. Normally the pin is the OR of all pending interrupt flags. When indicator mode is enabled and the host opens an SPI transaction whose first byte is the buffer-read opcode, the pin changes role for the rest of that transaction. It becomes a per-byte flow-control flag that tells the host whether the next received byte can be fetched yet.

After the opcode, the host fetches the length byte, then the payload bytes, then a link-quality byte, in that order. The opcode byte itself returns a status byte. Before each fetch the host waits for the pin to go low. The receive datapath reports how many bytes it has written so far, and the block compares that count with the number of bytes the host has already taken. A receive error pins the flag at "wait" for the rest of the transaction. Releasing chip select hands the pin straight back to interrupt reporting.

The SPI pins are sampled with the system clock. The SPI shifter for read data, the buffer RAM and the radio datapath are not part of this block.

Top module: `fbri_top`

## Requirements
- R1: With chip select high (`spi_cs_n` = 1), `irq_out` equals the OR of all bits of `irq_pending`.
- R2: Until the eighth rising SCLK edge of the first byte of a transaction has been sampled, `irq_out` keeps reporting interrupts (OR of `irq_pending`).
- R3: If `ind_enable` is 0 when the opcode byte completes, `irq_out` reports only interrupts for the whole transaction.
- R4: If the first byte differs from the buffer-read opcode `CMD_BUF_READ` (8'h20, all eight bits compared), `irq_out` reports only interrupts for the whole transaction.
- R5: After a buffer-read opcode completes with `ind_enable` = 1, `irq_out` is held high for at least `HOLD_CYC` system clocks after that final SCLK rising edge, whatever the write count is.
- R6: Once the hold-off has expired, and with no receive error, `irq_out` is low when the read index is below `wr_count` and high when it is not.
- R7: The read index starts at 0 for each transaction. It advances by one on each completed 8-bit transfer after the opcode, and saturates at its maximum.
- R8: A `rx_err` pulse during an indicator-mode transaction holds `irq_out` high until chip select is released, even if `wr_count` later grows. The next transaction starts clean.
- R9: A rising `spi_cs_n` returns `irq_out` to interrupt reporting in the same cycle, combinationally.
- R10: SPI is mode 0: MOSI is captured on SCLK rising edges, MSB first, and SCLK edges while chip select is high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from host |
| ind_enable | input | 1 | Indicator mode enable bit |
| wr_count | input | CNT_W | Bytes written to the buffer by the receive datapath |
| rx_err | input | 1 | Receive error pulse from the datapath |
| irq_pending | input | IRQ_W | Pending interrupt flags |
| irq_out | output | 1 | Interrupt / buffer readiness pin |

## Verification
A stuck or mis-decoded state shows up at the pin within one SPI byte. If the block enters indicator mode wrongly, the pin goes high during a register access. If the hold-off counter is wrong, the pin drops low tens of clocks too early after the opcode. A read index that skips or fails to clear gives a wrong low/high level right after the next completed byte, or at the first byte of the following transaction. A lost error latch lets the pin fall as soon as the write count grows. A late chip-select release would show as a stale level in the very cycle the host deselects.

// File: rtl/fbri_pkg.sv
// Shared types and constants for the buffer readiness indicator.
package fbri_pkg;
    // Controller states: idle / pass-through / hold-off / streaming indicator
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PASS   = 2'd1,
        ST_HOLD   = 2'd2,
        ST_STREAM = 2'd3
    } fbri_state_t;

    // Opcode that opens a buffer read transaction
    localparam logic [7:0] CMD_BUF_READ = 8'h20;
endpackage

// File: rtl/fbri_spi_rx.sv
// SPI receive front end.
// Synchronises SCLK, MOSI and chip select into the system clock domain and
// assembles mode-0 bytes, MSB first. Assumes SCLK is at most a quarter of
// the system clock rate, with MOSI stable around each rising SCLK edge.
module fbri_spi_rx #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       cs_n_sync,
    output logic       byte_done,
    output logic [7:0] byte_val,
    output logic       byte_first
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sclk_q, mosi_q, csn_q;
    logic          sclk_prev;
    logic [2:0]    bit_cnt;
    logic [6:0]    shreg;
    logic          first_pend;
    logic          sclk_rise;

    // Synchroniser chains for the three SPI inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            mosi_q <= '0;
            csn_q  <= '1;
        end else begin
            sclk_q <= {sclk_q[LAST-1:0], spi_sclk};
            mosi_q <= {mosi_q[LAST-1:0], spi_mosi};
            csn_q  <= {csn_q[LAST-1:0], spi_cs_n};
        end
    end

    assign cs_n_sync = csn_q[LAST];
    assign sclk_rise = sclk_q[LAST] & ~sclk_prev & ~csn_q[LAST];

    // Bit counter, shift register and byte completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev  <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            first_pend <= 1'b1;
            byte_done  <= 1'b0;
            byte_val   <= '0;
            byte_first <= 1'b0;
        end else begin
            sclk_prev <= sclk_q[LAST];
            byte_done <= 1'b0;
            if (csn_q[LAST]) begin
                bit_cnt    <= '0;
                first_pend <= 1'b1;
            end else if (sclk_rise) begin
                shreg   <= {shreg[5:0], mosi_q[LAST]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_done  <= 1'b1;
                    byte_val   <= {shreg, mosi_q[LAST]};
                    byte_first <= first_pend;
                    first_pend <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/fbri_ctrl.sv
// Indicator controller.
// Decodes the opcode byte, runs the hold-off timer, tracks the host read
// index and latches receive errors. Assumes byte_done is a one-cycle pulse
// and that cs_n_sync is the synchronised chip select.
module fbri_ctrl
    import fbri_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int HOLD_CYC = 38
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_sync,
    input  logic             byte_done,
    input  logic [7:0]       byte_val,
    input  logic             byte_first,
    input  logic             ind_enable,
    input  logic             rx_err,
    input  logic [CNT_W-1:0] wr_count,
    output fbri_state_t      state,
    output logic [CNT_W-1:0] rd_idx,
    output logic             err_lock,
    output logic             ind_active,
    output logic             ind_busy
);
    localparam int HC_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [HC_W-1:0]  HC_LOAD = HC_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] IDX_MAX = '1;

    logic [HC_W-1:0] hold_cnt;

    // State, hold-off timer, read index and error latch
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_sync) begin
            state    <= ST_IDLE;
            hold_cnt <= '0;
            rd_idx   <= '0;
            err_lock <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (byte_done && byte_first) begin
                        if (ind_enable && byte_val == CMD_BUF_READ) begin
                            state    <= ST_HOLD;
                            hold_cnt <= HC_LOAD;
                        end else begin
                            state <= ST_PASS;
                        end
                    end
                end
                ST_HOLD: begin
                    if (rx_err) err_lock <= 1'b1;
                    if (hold_cnt == '0) state <= ST_STREAM;
                    else                hold_cnt <= hold_cnt - 1'b1;
                end
                ST_STREAM: begin
                    if (rx_err) err_lock <= 1'b1;
                    if (byte_done && rd_idx != IDX_MAX) rd_idx <= rd_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Indicator level: high means the host must wait
    always_comb begin
        ind_active = (state == ST_HOLD) || (state == ST_STREAM);
        ind_busy   = (state == ST_HOLD) || err_lock || (rd_idx >= wr_count);
    end
endmodule

// File: rtl/fbri_top.sv
// Buffer readiness indicator top level.
// Routes either the interrupt summary or the readiness flag to the pin.
// Chip select gates the indicator combinationally so that releasing it
// restores interrupt reporting without synchroniser delay.
module fbri_top
    import fbri_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int IRQ_W       = 8,
    parameter int HOLD_CYC    = 38,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    input  logic             ind_enable,
    input  logic [CNT_W-1:0] wr_count,
    input  logic             rx_err,
    input  logic [IRQ_W-1:0] irq_pending,
    output logic             irq_out
);
    logic             cs_n_sync;
    logic             byte_done;
    logic [7:0]       byte_val;
    logic             byte_first;
    fbri_state_t      state;
    logic [CNT_W-1:0] rd_idx;
    logic             err_lock;
    logic             ind_active;
    logic             ind_busy;

    fbri_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_mosi   (spi_mosi),
        .cs_n_sync  (cs_n_sync),
        .byte_done  (byte_done),
        .byte_val   (byte_val),
        .byte_first (byte_first)
    );

    fbri_ctrl #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_sync  (cs_n_sync),
        .byte_done  (byte_done),
        .byte_val   (byte_val),
        .byte_first (byte_first),
        .ind_enable (ind_enable),
        .rx_err     (rx_err),
        .wr_count   (wr_count),
        .state      (state),
        .rd_idx     (rd_idx),
        .err_lock   (err_lock),
        .ind_active (ind_active),
        .ind_busy   (ind_busy)
    );

    // Pin source select
    always_comb begin
        if (ind_active && !spi_cs_n) irq_out = ind_busy;
        else                         irq_out = |irq_pending;
    end
endmodule

// File: rtl/fbri_chk.sv
// Property checker for fbri_top, attached through bind.
module fbri_chk
    import fbri_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int IRQ_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             spi_cs_n,
    input logic             cs_n_sync,
    input logic             rx_err,
    input logic [CNT_W-1:0] wr_count,
    input logic [IRQ_W-1:0] irq_pending,
    input logic             irq_out,
    input fbri_state_t      state,
    input logic [CNT_W-1:0] rd_idx,
    input logic             err_lock,
    input logic             ind_active
);
    AST_DESELECT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (irq_out == (|irq_pending))); // R9

    AST_PASS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS || state == ST_IDLE) |-> (irq_out == (|irq_pending))); // R3

    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !spi_cs_n) |-> irq_out); // R5

    AST_STREAM_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM && !err_lock && !spi_cs_n && rd_idx < wr_count) |-> !irq_out); // R6

    AST_ERR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_active && !spi_cs_n && !cs_n_sync && $past(ind_active) && $past(rx_err)
         && $past(!cs_n_sync)) |-> irq_out); // R8

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_sync && $past(!cs_n_sync)) |->
        (rd_idx == $past(rd_idx) || rd_idx == $past(rd_idx) + 1'b1)); // R7

    AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n_sync) |-> (rd_idx == '0)); // R7
endmodule

bind fbri_top fbri_chk #(.CNT_W(CNT_W), .IRQ_W(IRQ_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .cs_n_sync   (cs_n_sync),
    .rx_err      (rx_err),
    .wr_count    (wr_count),
    .irq_pending (irq_pending),
    .irq_out     (irq_out),
    .state       (state),
    .rd_idx      (rd_idx),
    .err_lock    (err_lock),
    .ind_active  (ind_active)
);

// File: tb/fbri_top_test.sv
module fbri_top_test;
    localparam int CNT_W = 8;
    localparam int IRQ_W = 8;
    localparam int HALF  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             spi_sclk = 1'b0;
    logic             spi_cs_n = 1'b1;
    logic             spi_mosi = 1'b0;
    logic             ind_enable = 1'b0;
    logic [CNT_W-1:0] wr_count = '0;
    logic             rx_err = 1'b0;
    logic [IRQ_W-1:0] irq_pending = '0;
    logic             irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fbri_top #(.CNT_W(CNT_W), .IRQ_W(IRQ_W), .HOLD_CYC(38)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .ind_enable(ind_enable), .wr_count(wr_count),
        .rx_err(rx_err), .irq_pending(irq_pending), .irq_out(irq_out)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic exp, input string req);
        #2;
        n_cmp++;
        if (irq_out !== exp) begin
            n_bad++;
            $display("FAIL %s: irq_out=%b expected=%b at %0t", req, irq_out, exp, $time);
        end
    endtask

    // Send the top n bits of b, MSB first, mode 0
    task automatic spi_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk);
            spi_mosi = b[i];
            wait_clk(HALF);
            spi_sclk = 1'b1;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] b);
        spi_bits(b, 8);
    endtask

    task automatic cs_low();
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic cs_high();
        @(negedge clk);
        spi_cs_n = 1'b1;
    endtask

    // Reset state and plain interrupt reporting
    task automatic t_reset();
        check(1'b0, "R1 reset");
        @(negedge clk); irq_pending = 8'h10;
        check(1'b1, "R1 pending");
        @(negedge clk); irq_pending = '0;
        check(1'b0, "R1 cleared");
    endtask

    // Main read burst: opcode, hold-off, per-byte flow control, release
    task automatic t_burst();
        ind_enable = 1'b1;
        wr_count = 8'd3;
        cs_low();
        spi_bits(8'h20, 7);
        wait_clk(10);
        irq_pending = 8'h01;
        check(1'b1, "R2 mid-opcode irq");
        irq_pending = '0;
        check(1'b0, "R2 mid-opcode quiet");
        spi_bits(8'h00, 1);             // last opcode bit is 0
        wait_clk(20);
        check(1'b1, "R5 hold-off");
        wait_clk(30);
        check(1'b0, "R6 length ready");
        spi_byte(8'h00); wait_clk(4);
        check(1'b0, "R6 idx1<3");
        spi_byte(8'h00); wait_clk(4);
        check(1'b0, "R6 idx2<3");
        spi_byte(8'h00); wait_clk(4);
        check(1'b1, "R7 idx3 not below 3");
        @(negedge clk); wr_count = 8'd4;
        check(1'b0, "R6 count grew");
        irq_pending = 8'h80;
        cs_high();
        check(1'b1, "R9 release shows irq");
        @(negedge clk); irq_pending = '0;
        check(1'b0, "R9 irq cleared");
        wait_clk(10);
    endtask

    // Enable bit low: interrupts only
    task automatic t_disabled();
        ind_enable = 1'b0;
        wr_count = '0;
        cs_low();
        spi_byte(8'h20);
        wait_clk(20);
        check(1'b0, "R3 disabled during hold window");
        wait_clk(30);
        check(1'b0, "R3 disabled empty buffer");
        cs_high();
        wait_clk(10);
    endtask

    // Other opcode: interrupts only; MSB-first order matters
    task automatic t_other_cmd();
        ind_enable = 1'b1;
        wr_count = '0;
        cs_low();
        spi_byte(8'h04);                // bit-reversed opcode
        wait_clk(20);
        check(1'b0, "R4 other opcode");
        wait_clk(30);
        check(1'b0, "R10 reversed opcode ignored");
        irq_pending = 8'h02;
        check(1'b1, "R4 irq passes");
        irq_pending = '0;
        cs_high();
        wait_clk(10);
    endtask

    // SCLK edges while deselected must not build a byte
    task automatic t_idle_clocks();
        ind_enable = 1'b1;
        wr_count = 8'd1;
        spi_bits(8'h20, 8);             // chip select still high
        cs_low();
        wait_clk(60);
        check(1'b0, "R10 no opcode from idle clocks");
        spi_byte(8'h20);
        wait_clk(20);
        check(1'b1, "R10 opcode after select");
        cs_high();
        wait_clk(10);
    endtask

    // Receive error locks busy; next burst is clean, empty buffer boundary
    task automatic t_error();
        ind_enable = 1'b1;
        wr_count = 8'd5;
        cs_low();
        spi_byte(8'h20);
        wait_clk(50);
        check(1'b0, "R6 ready before error");
        spi_byte(8'h00); wait_clk(4);
        @(negedge clk); rx_err = 1'b1;
        @(negedge clk); rx_err = 1'b0;
        wait_clk(3);
        check(1'b1, "R8 locked");
        wr_count = 8'd20;
        wait_clk(3);
        check(1'b1, "R8 locked despite count");
        cs_high();
        check(1'b0, "R8 released");
        wait_clk(10);
        wr_count = '0;
        cs_low();
        spi_byte(8'h20);
        wait_clk(50);
        check(1'b1, "R6 empty buffer busy");
        @(negedge clk); wr_count = 8'd1;
        check(1'b0, "R7 index restarted, R8 clean");
        cs_high();
        wait_clk(10);
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_burst();
        t_disabled();
        t_other_cmd();
        t_idle_clocks();
        t_error();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule